// File: doc/BRIEF.md
# Masked Round Weighted Queue Scheduler

This block chooses which of up to `NQ` output queues belonging to one port may send next. Each queue is configured with a small weight code. Codes 0 to 8 become an 8-bit participation mask: bit `r` of the mask says whether the queue may be served in round `r` of a repeating eight-round cycle. Code 9 makes the queue a strict-priority queue. A non-empty strict-priority queue always beats every weighted queue, and among strict-priority queues the lowest index wins.

Weighted queues take turns inside a round. The scan starts just past the queue granted last and stops at the port's last queue. When nothing eligible remains in the current round, the scheduler moves ahead to the nearest round (wrapping from 7 back to 0) that has an eligible queue and scans that round from queue 0. A grant appears as a registered one-hot vector with a valid flag. It stays fixed until downstream accepts it. Weights can be rewritten at any time through a single-queue write port, and the next decision uses the new weights.

Top module: `sched_mrwq`

## Requirements
- R1: Weight codes map to masks 0→0x00, 1→0x01, 2→0x11, 3→0x49, 4→0x55, 5→0x57, 6→0x77, 7→0x7F, 8→0xFF. A weighted queue is granted in round r (0..7) only when mask bit r is set, so over one full cycle a weight-8 queue is served 8 times for each service of a weight-1 queue.
- R2: A queue whose weight code is 0 is never granted, even when it is non-empty.
- R3: Whenever a non-empty strict-priority queue lies within the port, the grant goes to the lowest-indexed such queue and never to a weighted queue.
- R4: Weight code 9 makes the queue strict-priority with a full mask.
- R5: Weight codes 10 to 15 raise `cfg_err` for exactly the cycle after the write, and the queue then behaves as weight 8 (mask 0xFF). A valid write leaves `cfg_err` low.
- R6: After a weighted grant to queue i in round r, the next weighted grant goes to the lowest eligible queue above i in round r. If there is none, the round advances modulo 8 to the first round with an eligible queue, and that round is scanned from queue 0. Rounds start at 0 and the scan starts at queue 0 after reset.
- R7: While `gnt_vld` is high and `accept` is low, `gnt` and `gnt_vld` hold their values no matter how the inputs change.
- R8: `gnt` is one-hot when `gnt_vld` is high and zero when it is low. `gnt_vld` is low only when no queue is eligible in any round. A new decision is loaded on every edge where no grant is pending or `accept` is high.
- R9: The port ends at the lowest queue whose last-queue flag is set (queue NQ-1 when no flag is set). Queues above that point are never granted.
- R10: After reset, `gnt` is 0, `gnt_vld` is 0 and `cfg_err` is 0, and every queue holds weight 0 with no last-queue flag.
- R11: A weight written while the scheduler is running governs every decision loaded after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| q_nonempty | input | NQ | One bit per queue: the queue has something to send |
| cfg_we | input | 1 | Write strobe for one queue's configuration |
| cfg_qsel | input | $clog2(NQ) | Queue index being written |
| cfg_weight | input | 4 | Weight code: 0..8 weighted, 9 strict priority, 10..15 invalid |
| cfg_last | input | 1 | Marks the written queue as the port's last queue |
| cfg_err | output | 1 | Invalid weight code seen on the previous cycle's write |
| accept | input | 1 | Downstream takes the current grant |
| gnt | output | NQ | One-hot grant |
| gnt_vld | output | 1 | Grant is valid |

## Verification
Two functions can fall on the same edge. A configuration write can land on the edge where a new grant is loaded. An accept can also trigger a round advance on that same edge, in the same cycle. Both are provoked by rewriting a weight while queues stay non-empty and `accept` stays high, and by toggling `accept` in a fixed pattern during weighted scans. The bench's reference model applies its decision with the old weights first and the write second, and it checks every cycle's grant, valid flag and error flag against the design.

// File: rtl/sched_mrwq_pkg.sv
package sched_mrwq_pkg;

  localparam int ROUNDS      = 8;
  localparam int RW          = $clog2(ROUNDS);
  localparam int WCODE_W     = 4;
  localparam logic [WCODE_W-1:0] STATIC_CODE = 4'd9;
  localparam logic [WCODE_W-1:0] MAX_WEIGHT  = 4'd8;

  typedef struct packed {
    logic [ROUNDS-1:0] mask;
    logic              is_static;
    logic              is_last;
  } qcfg_t;

  // Spread the set bits of a weight evenly over the round cycle.
  function automatic logic [ROUNDS-1:0] weight_to_mask(input logic [WCODE_W-1:0] w);
    logic [ROUNDS-1:0] m;
    case (w)
      4'd0:    m = 8'h00;
      4'd1:    m = 8'h01;
      4'd2:    m = 8'h11;
      4'd3:    m = 8'h49;
      4'd4:    m = 8'h55;
      4'd5:    m = 8'h57;
      4'd6:    m = 8'h77;
      4'd7:    m = 8'h7F;
      default: m = 8'hFF;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/sched_mrwq_wenc.sv
module sched_mrwq_wenc
  import sched_mrwq_pkg::*;
(
  input  logic [WCODE_W-1:0] weight_i,
  output logic [ROUNDS-1:0]  mask_o,
  output logic               is_static_o,
  output logic               bad_o
);

  assign is_static_o = (weight_i == STATIC_CODE);
  assign bad_o       = (weight_i > STATIC_CODE);
  assign mask_o      = weight_to_mask(weight_i);

endmodule

// File: rtl/sched_mrwq_cfg.sv
module sched_mrwq_cfg
  import sched_mrwq_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we_i,
  input  logic [QW-1:0]         sel_i,
  input  logic [WCODE_W-1:0]    weight_i,
  input  logic                  last_i,
  output qcfg_t [NQ-1:0]        cfg_o,
  output logic                  err_o
);

  logic [ROUNDS-1:0] enc_mask;
  logic              enc_static;
  logic              enc_bad;

  sched_mrwq_wenc u_wenc (
    .weight_i    (weight_i),
    .mask_o      (enc_mask),
    .is_static_o (enc_static),
    .bad_o       (enc_bad)
  );

  for (genvar i = 0; i < NQ; i++) begin : g_q
    logic hit;
    assign hit = we_i && (sel_i == QW'(i));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cfg_o[i] <= '0;
      end else if (hit) begin
        cfg_o[i].mask      <= enc_mask;
        cfg_o[i].is_static <= enc_static;
        cfg_o[i].is_last   <= last_i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) err_o <= 1'b0;
    else        err_o <= we_i && enc_bad;
  end

  // R5
  bad_code_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && (weight_i > STATIC_CODE)) |=> err_o);

  // R5
  no_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> !err_o);

endmodule

// File: rtl/sched_mrwq_pick.sv
module sched_mrwq_pick
  import sched_mrwq_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW = $clog2(NQ + 1),
  localparam int SEGS = ROUNDS + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  qcfg_t [NQ-1:0]       cfg_i,
  input  logic [NQ-1:0]        nonempty_i,
  input  logic [RW-1:0]        round_i,
  input  logic [PW-1:0]        ptr_i,
  output logic                 pick_vld_o,
  output logic                 pick_static_o,
  output logic [QW-1:0]        pick_idx_o,
  output logic [RW-1:0]        pick_round_o
);

  function automatic logic [QW-1:0] lowest_set(input logic [NQ-1:0] v);
    logic [QW-1:0] idx;
    idx = '0;
    for (int k = NQ - 1; k >= 0; k--) begin
      if (v[k]) idx = QW'(k);
    end
    return idx;
  endfunction

  // Port end: lowest queue flagged as last.
  logic [QW-1:0] tail_idx;
  logic [NQ-1:0] last_vec;
  always_comb begin
    tail_idx = QW'(NQ - 1);
    for (int k = NQ - 1; k >= 0; k--) begin
      if (cfg_i[k].is_last) tail_idx = QW'(k);
    end
  end

  logic [NQ-1:0] in_port;
  logic [NQ-1:0] stat_elig;
  logic [NQ-1:0] wbase;

  for (genvar i = 0; i < NQ; i++) begin : g_elig
    assign last_vec[i]  = cfg_i[i].is_last;
    assign in_port[i]   = (QW'(i) <= tail_idx);
    assign stat_elig[i] = nonempty_i[i] && cfg_i[i].is_static && in_port[i];
    assign wbase[i]     = nonempty_i[i] && !cfg_i[i].is_static && in_port[i];
  end

  // Segment 0: current round above the pointer; 1..7: later rounds in full;
  // 8: current round again, below the pointer.
  logic [NQ-1:0] seg_cand [SEGS];

  for (genvar s = 0; s < SEGS; s++) begin : g_seg
    logic [RW-1:0] seg_round;
    assign seg_round = round_i + RW'(s);
    for (genvar i = 0; i < NQ; i++) begin : g_q
      logic in_win;
      if (s == 0) begin : g_first
        assign in_win = (PW'(i) >= ptr_i);
      end else if (s == SEGS - 1) begin : g_wrap
        assign in_win = (PW'(i) < ptr_i);
      end else begin : g_mid
        assign in_win = 1'b1;
      end
      assign seg_cand[s][i] = wbase[i] && cfg_i[i].mask[seg_round] && in_win;
    end
  end

  logic          w_found;
  logic [NQ-1:0] w_vec;
  logic [RW-1:0] w_round;

  always_comb begin
    w_found = 1'b0;
    w_vec   = '0;
    w_round = round_i;
    for (int s = 0; s < SEGS; s++) begin
      if (!w_found && (|seg_cand[s])) begin
        w_found = 1'b1;
        w_vec   = seg_cand[s];
        w_round = round_i + RW'(s);
      end
    end
  end

  always_comb begin
    pick_vld_o    = 1'b0;
    pick_static_o = 1'b0;
    pick_idx_o    = '0;
    pick_round_o  = round_i;
    if (|stat_elig) begin
      pick_vld_o    = 1'b1;
      pick_static_o = 1'b1;
      pick_idx_o    = lowest_set(stat_elig);
    end else if (w_found) begin
      pick_vld_o   = 1'b1;
      pick_idx_o   = lowest_set(w_vec);
      pick_round_o = w_round;
    end
  end

  logic [NQ-1:0] below_pick;
  assign below_pick = (NQ'(1) << pick_idx_o) - NQ'(1);

  // R1
  round_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_vld_o && !pick_static_o) |-> cfg_i[pick_idx_o].mask[pick_round_o]);

  // R2
  zero_weight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld_o |-> (cfg_i[pick_idx_o].mask != '0));

  // R3
  static_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pick_vld_o && !pick_static_o) |-> !cfg_i[pick_idx_o].is_static);

  // R9
  tail_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld_o |-> ((last_vec & below_pick) == '0));

  // R8
  pick_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pick_vld_o |-> nonempty_i[pick_idx_o]);

endmodule

// File: rtl/sched_mrwq.sv
module sched_mrwq
  import sched_mrwq_pkg::*;
#(
  parameter int NQ = 8,
  localparam int QW = (NQ > 1) ? $clog2(NQ) : 1,
  localparam int PW = $clog2(NQ + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NQ-1:0]       q_nonempty,
  input  logic                cfg_we,
  input  logic [QW-1:0]       cfg_qsel,
  input  logic [WCODE_W-1:0]  cfg_weight,
  input  logic                cfg_last,
  output logic                cfg_err,
  input  logic                accept,
  output logic [NQ-1:0]       gnt,
  output logic                gnt_vld
);

  qcfg_t [NQ-1:0] qcfg;

  sched_mrwq_cfg #(.NQ(NQ)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .we_i     (cfg_we),
    .sel_i    (cfg_qsel),
    .weight_i (cfg_weight),
    .last_i   (cfg_last),
    .cfg_o    (qcfg),
    .err_o    (cfg_err)
  );

  logic [RW-1:0] round_q;
  logic [PW-1:0] ptr_q;

  logic          pick_vld;
  logic          pick_static;
  logic [QW-1:0] pick_idx;
  logic [RW-1:0] pick_round;

  sched_mrwq_pick #(.NQ(NQ)) u_pick (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_i         (qcfg),
    .nonempty_i    (q_nonempty),
    .round_i       (round_q),
    .ptr_i         (ptr_q),
    .pick_vld_o    (pick_vld),
    .pick_static_o (pick_static),
    .pick_idx_o    (pick_idx),
    .pick_round_o  (pick_round)
  );

  // Decision event: a new grant may be loaded this edge.
  logic load_ev;
  logic wadv_ev;
  assign load_ev = !gnt_vld || accept;
  assign wadv_ev = load_ev && pick_vld && !pick_static;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt     <= '0;
      gnt_vld <= 1'b0;
      round_q <= '0;
      ptr_q   <= '0;
    end else begin
      if (load_ev) begin
        gnt_vld <= pick_vld;
        gnt     <= pick_vld ? (NQ'(1) << pick_idx) : '0;
      end
      if (wadv_ev) begin
        round_q <= pick_round;
        ptr_q   <= PW'(pick_idx) + PW'(1);
      end
    end
  end

  // R8
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));

  // R8
  gnt_vld_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_vld == (gnt != '0));

  // R7
  gnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_vld && !accept) |=> (gnt_vld && $stable(gnt)));

  // R6
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q <= PW'(NQ));

endmodule

// File: tb/sched_mrwq_tb.sv
`timescale 1ns/1ps
module sched_mrwq_tb;

  localparam int NQ = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NQ-1:0] q_nonempty;
  logic          cfg_we;
  logic [2:0]    cfg_qsel;
  logic [3:0]    cfg_weight;
  logic          cfg_last;
  logic          cfg_err;
  logic          accept;
  logic [NQ-1:0] gnt;
  logic          gnt_vld;

  always #2.5 clk = ~clk;

  sched_mrwq #(.NQ(NQ)) u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .q_nonempty (q_nonempty),
    .cfg_we     (cfg_we),
    .cfg_qsel   (cfg_qsel),
    .cfg_weight (cfg_weight),
    .cfg_last   (cfg_last),
    .cfg_err    (cfg_err),
    .accept     (accept),
    .gnt        (gnt),
    .gnt_vld    (gnt_vld)
  );

  // Vector: {accept toggle, last queue (8 = none), nonempty, weights q7..q0}
  localparam int NV = 7;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 4'd8, 8'h03, 32'h0000_0018},
    {1'b0, 4'd8, 8'h0F, 32'h0000_5432},
    {1'b0, 4'd8, 8'h0F, 32'h0000_0799},
    {1'b0, 4'd3, 8'h27, 32'h0040_8006},
    {1'b0, 4'd8, 8'h03, 32'h0000_00C1},
    {1'b0, 4'd8, 8'hFF, 32'h0000_0000},
    {1'b1, 4'd8, 8'h07, 32'h0000_0753}
  };

  // Reference model state
  logic [7:0]    m_mask [NQ];
  bit            m_stat [NQ];
  bit            m_last [NQ];
  int            m_round, m_ptr;
  logic [NQ-1:0] m_gnt;
  bit            m_vld, m_err;

  int n_chk  = 0;
  int n_fail = 0;

  function automatic logic [7:0] ref_mask(input int w);
    case (w)
      0: return 8'b0000_0000;
      1: return 8'b0000_0001;
      2: return 8'b0001_0001;
      3: return 8'b0100_1001;
      4: return 8'b0101_0101;
      5: return 8'b0101_0111;
      6: return 8'b0111_0111;
      7: return 8'b0111_1111;
      default: return 8'b1111_1111;
    endcase
  endfunction

  function automatic string tag_of(input int v);
    case (v)
      0: return "R1";
      1: return "R6";
      2: return "R3";
      3: return "R9";
      4: return "R5";
      5: return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NQ; i++) begin
      m_mask[i] = '0; m_stat[i] = 0; m_last[i] = 0;
    end
    m_round = 0; m_ptr = 0; m_gnt = '0; m_vld = 0; m_err = 0;
  endtask

  // Predict the edge: decision on the old configuration, then the write.
  task automatic model_step();
    if (!m_vld || accept) begin
      int tail = NQ - 1;
      int hit  = -1;
      int r0   = m_round;
      bit found = 0;
      for (int i = NQ - 1; i >= 0; i--) if (m_last[i]) tail = i;
      for (int i = 0; i <= tail; i++)
        if (hit < 0 && q_nonempty[i] && m_stat[i]) hit = i;
      if (hit >= 0) begin
        m_vld = 1; m_gnt = NQ'(1) << hit;
      end else begin
        m_gnt = '0;
        for (int s = 0; s <= 8; s++) begin
          int r = (r0 + s) % 8;
          for (int i = 0; i <= tail; i++) begin
            bit win = (s == 0) ? (i >= m_ptr) : ((s == 8) ? (i < m_ptr) : 1'b1);
            if (!found && q_nonempty[i] && !m_stat[i] && m_mask[i][r] && win) begin
              found = 1; m_round = r; m_ptr = i + 1; m_gnt = NQ'(1) << i;
            end
          end
        end
        m_vld = found;
      end
    end
    m_err = cfg_we && (cfg_weight > 4'd9);
    if (cfg_we) begin
      m_stat[cfg_qsel] = (cfg_weight == 4'd9);
      m_mask[cfg_qsel] = ref_mask(int'(cfg_weight));
      m_last[cfg_qsel] = cfg_last;
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (gnt !== m_gnt || gnt_vld !== m_vld || cfg_err !== m_err) begin
      n_fail++;
      $display("FAIL %s: gnt=%h vld=%b err=%b expected gnt=%h vld=%b err=%b",
               tag, gnt, gnt_vld, cfg_err, m_gnt, m_vld, m_err);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; q_nonempty = '0; cfg_we = 0; cfg_qsel = '0;
    cfg_weight = '0; cfg_last = 0; accept = 0;
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    check("R10");
  endtask

  task automatic cfg_write(input int q, input int w, input bit last, input string tag);
    cfg_we = 1; cfg_qsel = 3'(q); cfg_weight = 4'(w); cfg_last = last;
    tick(tag);
    cfg_we = 0; cfg_last = 0;
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 0; q_nonempty = '0; cfg_we = 0; cfg_qsel = '0;
    cfg_weight = '0; cfg_last = 0; accept = 0;

    // Table walk
    for (int v = 0; v < NV; v++) begin
      do_reset();
      for (int q = 0; q < NQ; q++)
        cfg_write(q, int'(VEC[v][4*q +: 4]), (int'(VEC[v][43:40]) == q), tag_of(v));
      q_nonempty = VEC[v][39:32];
      for (int t = 0; t < 24; t++) begin
        accept = VEC[v][44] ? ((t % 3) != 0) : 1'b1;
        tick(tag_of(v));
      end
    end

    // R10: idle after reset, nothing configured, queues non-empty
    do_reset();
    q_nonempty = '1; accept = 1;
    repeat (3) tick("R10");

    // R4: a lone strict-priority queue is served every cycle
    do_reset();
    cfg_write(2, 9, 0, "R4");
    cfg_write(0, 8, 0, "R4");
    q_nonempty = 8'h05; accept = 1;
    repeat (6) tick("R4");

    // R11: weight rewritten while running
    do_reset();
    cfg_write(0, 8, 0, "R11");
    cfg_write(1, 1, 0, "R11");
    q_nonempty = 8'h03; accept = 1;
    repeat (10) tick("R11");
    cfg_write(1, 8, 0, "R11");
    repeat (12) tick("R11");
    cfg_write(0, 0, 0, "R11");
    repeat (6) tick("R11");

    // R7: hold while accept is low and inputs move
    do_reset();
    cfg_write(0, 4, 0, "R7");
    cfg_write(1, 4, 0, "R7");
    q_nonempty = 8'h03; accept = 1;
    tick("R7");
    accept = 0;
    q_nonempty = 8'h02; tick("R7");
    q_nonempty = 8'h00; tick("R7");
    cfg_write(0, 0, 0, "R7");
    q_nonempty = 8'h03; accept = 1;
    repeat (4) tick("R7");

    // R5: invalid code pulse then valid write keeps flag low
    do_reset();
    cfg_write(3, 15, 0, "R5");
    cfg_write(3, 2, 0, "R5");
    tick("R5");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule